// File: doc/BRIEF.md
# Pixel Color Correction Matrix

This block corrects a display panel's color response by passing every RGB pixel through a programmable 3x3 matrix. Each coefficient is a signed fixed-point value in which 256 means a gain of one. Each output channel is the weighted sum of the red, green and blue inputs for that channel's row. The sum is divided by 256 and then saturated to the pixel range. Pixels arrive as a stream with a valid strobe and leave two clocks later with their valid strobe.

Software writes the nine coefficients through a small indexed write port into a staging set. The block copies the staging set into the working set only in a cycle where the start-of-frame input is high, so no frame is ever processed with two different matrices. An enable input selects between the corrected result and the unmodified pixel. Both paths have the same latency.

Top module: `color_matrix`

## Requirements
- R1: Each output channel o equals floor((C[o][0]*R + C[o][1]*G + C[o][2]*B) / 256), saturated to 0..255. Row o=0 drives red, o=1 green and o=2 blue. Columns 0, 1 and 2 take the red, green and blue inputs.
- R2: Coefficients 256 on the diagonal and 0 elsewhere reproduce the input pixel exactly.
- R3: Coefficients are 12-bit two's complement (range -2048..2047), so values such as -129 and 370 are applied with their sign. Example: the row (-129, -129, 370) with all inputs at 128 gives 56.
- R4: A channel whose sum is negative outputs 0.
- R5: A channel whose scaled sum exceeds 255 outputs 255.
- R6: An input pixel of 0,0,0 gives an output of 0,0,0 for any coefficients.
- R7: out_valid equals in_valid delayed by exactly two clock cycles. The output pixel belongs to the input sampled in that same cycle.
- R8: When enable is low in the input cycle, the output pixel equals the input pixel, with the same two-cycle latency.
- R9: A write with cfg_we high stores cfg_data at cfg_idx = 3*row + column in the staging set. The working set takes the staging set's value from before that edge whenever sof is high. The pixel presented in the sof cycle already uses the new set, and no other cycle changes the working set.
- R10: After reset both coefficient sets hold the identity matrix, and out_valid and the output pixel are 0.
- R11: Writes with cfg_idx of 9 to 15 change no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 applies the matrix, 0 passes pixels through |
| sof | input | 1 | Start of frame; loads the staged coefficients |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | 4 | Coefficient index, 3*row + column |
| cfg_data | input | 12 | Signed coefficient value |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 8 | Input red |
| in_g | input | 8 | Input green |
| in_b | input | 8 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |

## Verification
Directed pixels go first. Identity-matrix pixels show whether the rows or columns are swapped. Mid-grey through the blue-correction row checks signed products and scaling. Pure red and pure blue through the same row drive the two saturation limits, and a black pixel checks that no offset leaks in. The test then writes staged coefficients with and without a frame start, and with out-of-range indexes, to show when a new matrix takes effect. Random stretches with random coefficients, gaps in the valid strobe and enable toggling then compare every output cycle against a bench model. These stretches separate latency faults from arithmetic faults.

// File: rtl/color_matrix.sv
module color_matrix #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int FRAC   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     sof,
  input  logic                     cfg_we,
  input  logic [3:0]               cfg_idx,
  input  logic signed [COEF_W-1:0] cfg_data,
  input  logic                     in_valid,
  input  logic [PIX_W-1:0]         in_r,
  input  logic [PIX_W-1:0]         in_g,
  input  logic [PIX_W-1:0]         in_b,
  output logic                     out_valid,
  output logic [PIX_W-1:0]         out_r,
  output logic [PIX_W-1:0]         out_g,
  output logic [PIX_W-1:0]         out_b
);
  localparam int ACC_W = PIX_W + COEF_W + 3;
  localparam int NCOEF = 9;
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1 << FRAC);
  localparam logic signed [ACC_W-1:0]  PMAX  = ACC_W'((1 << PIX_W) - 1);

  logic [PIX_W-1:0]         pix_in [3];
  logic signed [COEF_W-1:0] staged [NCOEF];
  logic signed [COEF_W-1:0] working[NCOEF];
  logic signed [COEF_W-1:0] coef_sel[NCOEF];
  logic signed [ACC_W-1:0]  acc_d[3];
  logic signed [ACC_W-1:0]  acc_q[3];
  logic [PIX_W-1:0]         byp_q[3];
  logic [PIX_W-1:0]         pix_out[3];
  logic                     v1, en1;

  assign pix_in[0] = in_r;
  assign pix_in[1] = in_g;
  assign pix_in[2] = in_b;
  assign out_r = pix_out[0];
  assign out_g = pix_out[1];
  assign out_b = pix_out[2];

  always_comb
    for (int i = 0; i < NCOEF; i++) coef_sel[i] = sof ? staged[i] : working[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) begin
        staged[i]  <= (i % 4 == 0) ? UNITY : '0;
        working[i] <= (i % 4 == 0) ? UNITY : '0;
      end
    end else begin
      if (sof)
        for (int i = 0; i < NCOEF; i++) working[i] <= staged[i];
      if (cfg_we && cfg_idx < 4'(NCOEF))
        staged[cfg_idx] <= cfg_data;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_row
    logic signed [ACC_W-1:0] scaled;
    logic [PIX_W-1:0]        sat;

    always_comb begin
      acc_d[g] = '0;
      for (int c = 0; c < 3; c++)
        acc_d[g] = acc_d[g] + ACC_W'(coef_sel[g*3+c])
                 * $signed({{(ACC_W-PIX_W){1'b0}}, pix_in[c]});
    end

    assign scaled = acc_q[g] >>> FRAC;
    assign sat = (scaled < 0) ? '0 : (scaled > PMAX) ? PMAX[PIX_W-1:0] : scaled[PIX_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q[g]   <= '0;
        byp_q[g]   <= '0;
        pix_out[g] <= '0;
      end else begin
        acc_q[g]   <= acc_d[g];
        byp_q[g]   <= pix_in[g];
        pix_out[g] <= en1 ? sat : byp_q[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      en1       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      en1       <= enable;
      out_valid <= v1;
    end
  end

  logic sel_ident;
  always_comb begin
    sel_ident = 1'b1;
    for (int i = 0; i < NCOEF; i++)
      if (coef_sel[i] != ((i % 4 == 0) ? UNITY : '0)) sel_ident = 1'b0;
  end

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  a_r7_valid_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !enable) |-> ##2
      (out_r == $past(in_r, 2) && out_g == $past(in_g, 2) && out_b == $past(in_b, 2)));
  a_r6_black: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enable && in_r == '0 && in_g == '0 && in_b == '0) |-> ##2
      (out_r == '0 && out_g == '0 && out_b == '0));
  a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enable && sel_ident) |-> ##2
      (out_r == $past(in_r, 2) && out_g == $past(in_g, 2) && out_b == $past(in_b, 2)));

  for (genvar i = 0; i < NCOEF; i++) begin : g_chk
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sof |=> $stable(working[i]));
    a_r11_bad_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx >= 4'(NCOEF)) |=> $stable(staged[i]));
  end
endmodule

// File: tb/tb_color_matrix.sv
module tb_color_matrix;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, sof = 1'b0, cfg_we = 1'b0, in_valid = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic signed [11:0] cfg_data = '0;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic out_valid;
  logic [7:0] out_r, out_g, out_b;

  int vectors = 0, errors = 0;
  int stg[9], wrk[9];
  bit ev[2];
  int er[2], eg[2], eb[2];
  string et[2];

  always #10 clk = ~clk;

  color_matrix dut (.clk, .rst_n, .enable, .sof, .cfg_we, .cfg_idx, .cfg_data,
                    .in_valid, .in_r, .in_g, .in_b, .out_valid, .out_r, .out_g, .out_b);

  function automatic int chan(int m[9], int row, int r, int g, int b);
    int s = (m[row*3] * r + m[row*3+1] * g + m[row*3+2] * b) >>> 8;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic step(bit v, bit en, bit sf, bit we, int idx, int data,
                      int r, int g, int b, string tag);
    int use_m[9];
    @(negedge clk);
    vectors++;
    if (out_valid !== ev[1]) begin
      errors++;
      $display("FAIL %s R7 out_valid=%0b expected %0b", et[1], out_valid, ev[1]);
    end else if (ev[1] && (out_r != er[1] || out_g != eg[1] || out_b != eb[1])) begin
      errors++;
      $display("FAIL %s pixel=%0d,%0d,%0d expected %0d,%0d,%0d",
               et[1], out_r, out_g, out_b, er[1], eg[1], eb[1]);
    end
    ev[1] = ev[0]; er[1] = er[0]; eg[1] = eg[0]; eb[1] = eb[0]; et[1] = et[0];
    enable = en; sof = sf; cfg_we = we; cfg_idx = 4'(idx); cfg_data = 12'(data);
    in_valid = v; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    for (int i = 0; i < 9; i++) use_m[i] = sf ? stg[i] : wrk[i];
    ev[0] = v; et[0] = tag;
    er[0] = en ? chan(use_m, 0, r, g, b) : r;
    eg[0] = en ? chan(use_m, 1, r, g, b) : g;
    eb[0] = en ? chan(use_m, 2, r, g, b) : b;
    if (sf) for (int i = 0; i < 9; i++) wrk[i] = stg[i];
    if (we && idx < 9) stg[idx] = data;
  endtask

  task automatic px(bit en, int r, int g, int b, string tag);
    step(1, en, 0, 0, 0, 0, r, g, b, tag);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    for (int i = 0; i < 9; i++) begin stg[i] = (i % 4 == 0) ? 256 : 0; wrk[i] = stg[i]; end
    ev = '{0, 0};
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || out_r !== 8'd0 || out_g !== 8'd0 || out_b !== 8'd0) begin
      errors++;
      $display("FAIL R10 reset outputs %0b %0d %0d %0d expected 0 0 0 0", out_valid, out_r, out_g, out_b);
    end
    rst_n = 1'b1;
    // R10 R2: identity after reset
    px(1, 200, 17, 99, "R10_R2");
    px(1, 255, 0, 128, "R2");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7_gap");
    // R9: stage blue row without frame start, still identity
    step(0, 1, 0, 1, 6, -129, 0, 0, 0, "R9");
    step(0, 1, 0, 1, 7, -129, 0, 0, 0, "R9");
    step(0, 1, 0, 1, 8, 370, 0, 0, 0, "R9");
    px(1, 128, 128, 128, "R9_staged_only");
    // R11: bad index write before frame start
    step(0, 1, 0, 1, 12, -2000, 0, 0, 0, "R11");
    step(1, 1, 1, 0, 0, 0, 128, 128, 128, "R9_R3_grey");
    px(1, 0, 0, 0, "R6_black");
    px(1, 0, 0, 255, "R5_sat_high");
    px(1, 255, 0, 0, "R4_sat_low");
    px(1, 255, 255, 0, "R4_two_neg");
    px(0, 12, 34, 56, "R8_bypass");
    px(0, 255, 0, 255, "R8_bypass");
    px(1, 40, 50, 60, "R11_R1");
    step(0, 1, 0, 1, 15, 1000, 0, 0, 0, "R11");
    step(1, 1, 1, 0, 0, 0, 90, 91, 92, "R11_after_sof");
    // R1 R3: random coefficients, staging, enable and valid gaps
    for (int n = 0; n < 4000; n++) begin
      bit v = ($urandom % 4) != 0;
      bit en = ($urandom % 8) != 0;
      bit sf = ($urandom % 40) == 0;
      bit we = ($urandom % 4) == 0;
      int idx = $urandom % 16;
      int data = int'($urandom % 4096) - 2048;
      int r = ($urandom % 5 == 0) ? 255 : $urandom % 256;
      int g = $urandom % 256;
      int b = ($urandom % 7 == 0) ? 0 : $urandom % 256;
      step(v, en, sf, we, idx, data, r, g, b, "R1_R3_random");
    end
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7_drain");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7_drain");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule